// File: doc/BRIEF.md
# NAND Page Hamming Parity Accumulator

This block builds the single-error-correcting Hamming check word for one 512-byte NAND page. It sits beside the byte lane of a flash interface and sees every data byte as it crosses, whether the processor is writing the page out or reading it back. The byte goes on unchanged. While that happens, two sets of parity bits are updated. The first set is nine pairs of line parities, one pair for each bit of the byte's position in the page. The second set is six column parities taken across bit positions inside each byte.

Software clears the accumulator by writing a configuration word with its clear bit set. It then streams the page and reads back the 24-bit check word in three byte-wide pieces. The word is packed in a fixed layout and inverted, so a page of all-ones flash data yields a check word that matches an erased spare area. Software does the error location and correction from the stored and recomputed words.

Top module: `nand_ecc_acc`

## Requirements
- R1: While reset is high, and in the cycle after it falls, the accumulator and the byte position are zero, so all three readout bytes read 0xFF.
- R2: A cycle with cfg_wr high and cfg_wdata bit 12 set clears the line parities, column parities and byte position at the next clock edge. A cfg_wr with bit 12 low changes none of them.
- R3: byte_out equals byte_in at all times, whatever the enable and valid inputs are.
- R4: A byte updates the state only when byte_valid and enable are both high at the clock edge. Otherwise the readout and the byte position stay unchanged.
- R5: Each accepted byte b is XORed into six column parities. In word-bit order 18 to 23 these are ^(b&0xAA), ^(b&0x55), ^(b&0xCC), ^(b&0x33), ^(b&0xF0) and ^(b&0x0F).
- R6: For k = 0..8, raw word bit 2k collects the XOR parity of every accepted byte whose page index has bit k set. Bit 2k+1 collects the parity of the bytes whose index has bit k clear.
- R7: The readout is the bitwise inverse of the 24-bit raw word. A single byte 0x01 at index 0 reads back as 0x555555.
- R8: rd_sel 0, 1 and 2 return bits 7:0, 15:8 and 23:16 of the inverted word. rd_sel 3 returns 0x00. rd_data is combinational from the stored state.
- R9: The page index starts at 0, steps by one for each accepted byte, and wraps from 511 to 0.
- R10: When a clearing configuration write and an accepted byte fall in the same cycle, the clear wins and the byte leaves no trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data; bit 12 requests a clear |
| enable | input | 1 | Controller enabled; bytes are ignored when low |
| byte_valid | input | 1 | A data byte crosses the interface this cycle |
| byte_in | input | 8 | Data byte, either direction |
| byte_out | output | 8 | Data byte passed on unchanged |
| rd_sel | input | 2 | Readout byte offset |
| rd_data | output | 8 | Selected byte of the inverted check word |

## Verification
The assertions assume that every input is a known 0 or 1 at each rising edge, and that a clearing write is the only way software restarts a page. The properties also assume that the accumulated state is stable between accepted bytes. The stimulus changes inputs only on falling edges and always drives defined values. It mixes accepted bytes with gaps, disabled bytes and non-clearing configuration writes, so every hold property is exercised, and it runs past 512 bytes to reach the wrap.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    localparam int DATA_W   = 8;
    localparam int COL_W    = 6;
    localparam int CFG_W    = 16;
    localparam int CLR_BIT  = 12;

    typedef struct packed {
        logic              clear;
        logic              take;
        logic [DATA_W-1:0] data;
    } ecc_step_t;

    function automatic logic [COL_W-1:0] col_terms(input logic [DATA_W-1:0] b);
        logic [COL_W-1:0] t;
        t[0] = b[1] ^ b[3] ^ b[5] ^ b[7];
        t[1] = b[0] ^ b[2] ^ b[4] ^ b[6];
        t[2] = b[2] ^ b[3] ^ b[6] ^ b[7];
        t[3] = b[0] ^ b[1] ^ b[4] ^ b[5];
        t[4] = ^b[7:4];
        t[5] = ^b[3:0];
        return t;
    endfunction

endpackage

// File: rtl/ecc_line_acc.sv
module ecc_line_acc
    import nand_ecc_pkg::*;
#(
    parameter int ADDR_BITS = 9
) (
    input  logic                 clk,
    input  ecc_step_t            step,
    output logic [ADDR_BITS-1:0] hi_par,
    output logic [ADDR_BITS-1:0] lo_par
);

    logic [ADDR_BITS-1:0] idx_q;
    logic                 byte_par;

    assign byte_par = ^step.data;

    always_ff @(posedge clk) begin
        if (step.clear) begin
            idx_q <= '0;
        end else if (step.take) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    for (genvar k = 0; k < ADDR_BITS; k++) begin : g_pair
        always_ff @(posedge clk) begin
            if (step.clear) begin
                hi_par[k] <= 1'b0;
                lo_par[k] <= 1'b0;
            end else if (step.take && byte_par) begin
                if (idx_q[k]) hi_par[k] <= ~hi_par[k];
                else          lo_par[k] <= ~lo_par[k];
            end
        end
    end

endmodule

// File: rtl/ecc_col_acc.sv
module ecc_col_acc
    import nand_ecc_pkg::*;
(
    input  logic             clk,
    input  ecc_step_t        step,
    output logic [COL_W-1:0] col_par
);

    always_ff @(posedge clk) begin
        if (step.clear) begin
            col_par <= '0;
        end else if (step.take) begin
            col_par <= col_par ^ col_terms(step.data);
        end
    end

endmodule

// File: rtl/ecc_readout.sv
module ecc_readout
    import nand_ecc_pkg::*;
#(
    parameter int ADDR_BITS = 9,
    parameter int SEL_W     = 2
) (
    input  logic [ADDR_BITS-1:0] hi_par,
    input  logic [ADDR_BITS-1:0] lo_par,
    input  logic [COL_W-1:0]     col_par,
    input  logic [SEL_W-1:0]     rd_sel,
    output logic [2*ADDR_BITS+COL_W-1:0] raw_word,
    output logic [DATA_W-1:0]    rd_data
);

    localparam int LINE_W = 2 * ADDR_BITS;
    localparam int WORD_W = LINE_W + COL_W;
    localparam int NBYTES = (WORD_W + DATA_W - 1) / DATA_W;
    localparam int PAD_W  = NBYTES * DATA_W;

    logic [PAD_W-1:0] inv_word;

    for (genvar k = 0; k < ADDR_BITS; k++) begin : g_pack
        assign raw_word[2*k]   = hi_par[k];
        assign raw_word[2*k+1] = lo_par[k];
    end
    assign raw_word[LINE_W +: COL_W] = col_par;

    assign inv_word = ~{{(PAD_W-WORD_W){1'b0}}, raw_word};

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (int'(rd_sel) == i) rd_data = inv_word[i*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
    import nand_ecc_pkg::*;
#(
    parameter int ADDR_BITS = 9,
    parameter int SEL_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              enable,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_in,
    output logic [DATA_W-1:0] byte_out,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data
);

    localparam int WORD_W = 2 * ADDR_BITS + COL_W;

    ecc_step_t            step;
    logic [ADDR_BITS-1:0] hi_par;
    logic [ADDR_BITS-1:0] lo_par;
    logic [COL_W-1:0]     col_par;
    logic [WORD_W-1:0]    ecc_raw;

    assign byte_out   = byte_in;
    assign step.clear = rst | (cfg_wr & cfg_wdata[CLR_BIT]);
    assign step.take  = byte_valid & enable;
    assign step.data  = byte_in;

    ecc_line_acc #(.ADDR_BITS(ADDR_BITS)) u_line (
        .clk    (clk),
        .step   (step),
        .hi_par (hi_par),
        .lo_par (lo_par)
    );

    ecc_col_acc u_col (
        .clk     (clk),
        .step    (step),
        .col_par (col_par)
    );

    ecc_readout #(.ADDR_BITS(ADDR_BITS), .SEL_W(SEL_W)) u_out (
        .hi_par   (hi_par),
        .lo_par   (lo_par),
        .col_par  (col_par),
        .rd_sel   (rd_sel),
        .raw_word (ecc_raw),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/nand_ecc_acc_chk.sv
module nand_ecc_acc_chk
    import nand_ecc_pkg::*;
#(
    parameter int ADDR_BITS = 9,
    parameter int SEL_W     = 2
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          cfg_wr,
    input logic [CFG_W-1:0]              cfg_wdata,
    input logic                          enable,
    input logic                          byte_valid,
    input logic [DATA_W-1:0]             byte_in,
    input logic [DATA_W-1:0]             byte_out,
    input logic [SEL_W-1:0]              rd_sel,
    input logic [DATA_W-1:0]             rd_data,
    input logic [2*ADDR_BITS+COL_W-1:0]  raw
);

    localparam int LINE_W = 2 * ADDR_BITS;

    logic clr_req;
    assign clr_req = cfg_wr && cfg_wdata[CLR_BIT];

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> raw == '0);

    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> raw == '0);

    assert_pass_through_R3: assert property (@(posedge clk) disable iff (rst)
        byte_out == byte_in);

    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !(byte_valid && enable) && !clr_req |=> $stable(raw));

    assert_line_flip_count_R6: assert property (@(posedge clk) disable iff (rst)
        byte_valid && enable && !clr_req && (^byte_in)
        |=> $countones(raw[LINE_W-1:0] ^ $past(raw[LINE_W-1:0])) == ADDR_BITS);

    assert_line_even_hold_R6: assert property (@(posedge clk) disable iff (rst)
        byte_valid && enable && !clr_req && !(^byte_in)
        |=> $stable(raw[LINE_W-1:0]));

    assert_unused_offset_R8: assert property (@(posedge clk) disable iff (rst)
        rd_sel == SEL_W'(3) |-> rd_data == '0);

endmodule

bind nand_ecc_acc nand_ecc_acc_chk #(.ADDR_BITS(ADDR_BITS), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .enable     (enable),
    .byte_valid (byte_valid),
    .byte_in    (byte_in),
    .byte_out   (byte_out),
    .rd_sel     (rd_sel),
    .rd_data    (rd_data),
    .raw        (ecc_raw)
);

// File: tb/nand_ecc_acc_bench.sv
module nand_ecc_acc_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        enable = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_in = '0;
    logic [7:0]  byte_out;
    logic [1:0]  rd_sel = '0;
    logic [7:0]  rd_data;

    int checks = 0;
    int failures = 0;

    bit m_hi[9];
    bit m_lo[9];
    bit m_col[6];
    int m_idx;

    always #10 clk = ~clk;

    nand_ecc_acc u_nand_ecc_acc (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .enable     (enable),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .byte_out   (byte_out),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data)
    );

    function automatic logic [23:0] model_word();
        logic [23:0] w = '0;
        for (int k = 0; k < 9; k++) begin
            w[2*k]   = m_hi[k];
            w[2*k+1] = m_lo[k];
        end
        for (int g = 0; g < 6; g++) w[18+g] = m_col[g];
        return ~w;
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < 9; k++) begin m_hi[k] = 0; m_lo[k] = 0; end
        for (int g = 0; g < 6; g++) m_col[g] = 0;
        m_idx = 0;
    endtask

    task automatic step(input bit r, input bit cw, input logic [15:0] cd,
                        input bit en, input bit v, input logic [7:0] d, input string tag);
        logic [7:0] masks [6];
        logic [23:0] ew;
        masks = '{8'hAA, 8'h55, 8'hCC, 8'h33, 8'hF0, 8'h0F};
        rst = r; cfg_wr = cw; cfg_wdata = cd; enable = en; byte_valid = v; byte_in = d;
        @(posedge clk);
        if (r || (cw && cd[12])) begin
            model_clear();
        end else if (v && en) begin
            bit p;
            p = ^d;
            for (int k = 0; k < 9; k++) begin
                if ((m_idx >> k) & 1) m_hi[k] ^= p;
                else                  m_lo[k] ^= p;
            end
            for (int g = 0; g < 6; g++) m_col[g] ^= ^(d & masks[g]);
            m_idx = (m_idx + 1) % 512;
        end
        #2;
        check8({tag, " R3 passthrough"}, byte_out, d);
        ew = model_word();
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1;
            check8($sformatf("%s R8 sel=%0d", tag, s), rd_data,
                   (s < 3) ? ew[8*s +: 8] : 8'h00);
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        model_clear();
        @(negedge clk);
        // R1: reset state reads all ones
        step(1, 0, 16'h0, 0, 0, 8'h00, "R1 reset");
        step(1, 0, 16'h0, 1, 1, 8'h5A, "R1 reset");
        step(0, 0, 16'h0, 0, 0, 8'h00, "R1 after");
        // R5 R6 R7: single byte 0x01 at index 0 gives 0x555555
        step(0, 0, 16'h0, 1, 1, 8'h01, "R5 R6 R7 single");
        checks++;
        if (model_word() !== 24'h555555) begin
            failures++;
            $display("FAIL R7 actual=%06h expected=555555", model_word());
        end
        // R2: clearing write
        step(0, 1, 16'h1000, 0, 0, 8'h00, "R2 clear");
        // R4: disabled and invalid bytes ignored
        step(0, 0, 16'h0, 1, 1, 8'h80, "R4 accept");
        step(0, 0, 16'h0, 0, 1, 8'hFF, "R4 disabled");
        step(0, 0, 16'h0, 1, 0, 8'h7F, "R4 not valid");
        // R2: non-clearing write leaves state
        step(0, 1, 16'hEFFF, 1, 0, 8'h00, "R2 no clear");
        step(0, 0, 16'h0, 1, 1, 8'h03, "R6 even byte");
        // R10: clear and byte together
        step(0, 1, 16'h1000, 1, 1, 8'h01, "R10 clear wins");
        // full page plus wrap, with gaps and disabled bytes (R5 R6 R9)
        for (int i = 0; i < 1300; i++) begin
            logic [7:0] d;
            bit en;
            bit v;
            d  = 8'($urandom);
            en = ($urandom % 8) != 0;
            v  = ($urandom % 5) != 0;
            step(0, ((i % 97) == 50), 16'h0800, en, v, d, "R9 stream");
        end
        // R9: walk to index 511 with single-bit bytes
        step(0, 1, 16'h1000, 0, 0, 8'h00, "R2 clear");
        for (int i = 0; i < 520; i++) begin
            step(0, 0, 16'h0, 1, 1, (i == 511 || i == 512) ? 8'h10 : 8'h00, "R9 wrap");
        end
        summary();
        $finish;
    end

endmodule